// File: doc/BRIEF.md
# Reduction Line Buffer

This block sits beside one core's private cache and holds lines that the core updates with a scatter-add reduction. Such a line is kept non-coherent: several cores may each hold their own modified partial copy at the same time. The core's reduction-add is never held up waiting for ownership of the line. On the first add to a line that the buffer does not hold, the buffer does three things. It picks a free entry. It fills that entry with zero, the identity for addition, and applies the add to it in the same step. It raises a start-reduction request toward the line's home directory. Later adds to a line the buffer already holds just accumulate into it.

When the directory gathers the partial results, it presents a collect request for a line. One cycle later the buffer answers with the full partial line and frees the entry. The directory then sums the partial lines from all participating cores. A line is sixteen 32-bit words (64 bytes). The buffer holds four lines, and when all four are busy, an add to a fifth line is back-pressured.

Top module: `red_line_buf`

## Requirements
- R1: After reset no line is held, `add_ready` is 1, and `start_valid` and `rep_valid` are 0.
- R2: An add is accepted on a clock edge where `add_valid` and `add_ready` are both 1. An accepted add to a line not held allocates an entry, and in the next cycle `start_valid` is 1 for one cycle with `start_line` equal to that line.
- R3: An accepted add to a line already held raises no start request; it adds `add_value` into word `add_word` of that line, modulo 2^32.
- R4: A newly allocated line holds `add_value` in word `add_word` and zero in every other word.
- R5: A collect request (`col_valid` 1 for one cycle) for a held line gives, in the next cycle, `rep_valid`=1, `rep_hit`=1 and the whole line on `rep_data`. Word i sits at bits [32i+31:32i]. The entry is freed, so a later add to that line starts from zero and sends a new start request.
- R6: A collect request for a line not held gives `rep_valid`=1, `rep_hit`=0 and `rep_data` all zero, and changes no held line.
- R7: With all four entries busy, an add to a line not held sees `add_ready`=0 and is not taken, while an add to a held line is still accepted.
- R8: In any cycle where `col_valid` is 1, `add_ready` is 0, so no add is taken in that cycle.
- R9: Distinct lines are kept in separate entries and never affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| add_valid | input | 1 | Core presents a reduction-add |
| add_ready | output | 1 | Add can be taken this cycle |
| add_line | input | LINE_W | Line address of the add |
| add_word | input | 4 | Word index within the line |
| add_value | input | 32 | Value to add |
| start_valid | output | 1 | Start-reduction request to the home directory |
| start_line | output | LINE_W | Line address of the start request |
| col_valid | input | 1 | Directory collect request |
| col_line | input | LINE_W | Line to collect |
| rep_valid | output | 1 | Partial-line reply valid |
| rep_hit | output | 1 | Reply carries a held line |
| rep_data | output | 512 | Partial line, word i at bits [32i+31:32i] |

## Verification
The assertions check several rules on every cycle. No two entries ever match the same line. Every collect request is answered in the next cycle, and a reply that misses carries all-zero data. A collect request always blocks adds, and an add to a new line while the buffer is full is always refused. A hit never produces a start request. The bench's scenarios are needed for the arithmetic itself: the accumulated word values, wrap-around at 2^32, and the zero fill of a new line. They are also needed to show that freeing an entry really restarts the line from zero, and that an add refused at full or during a collect leaves no trace.

// File: rtl/red_line_buf.sv
module red_line_buf #(
  parameter int LINE_W  = 26,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 16,
  parameter int ENTRIES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    add_valid,
  output logic                    add_ready,
  input  logic [LINE_W-1:0]       add_line,
  input  logic [$clog2(WORDS)-1:0] add_word,
  input  logic [WORD_W-1:0]       add_value,
  output logic                    start_valid,
  output logic [LINE_W-1:0]       start_line,
  input  logic                    col_valid,
  input  logic [LINE_W-1:0]       col_line,
  output logic                    rep_valid,
  output logic                    rep_hit,
  output logic [WORDS*WORD_W-1:0] rep_data
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [LINE_W-1:0]  tag [ENTRIES];
  logic [WORD_W-1:0]  dat [ENTRIES][WORDS];

  logic [ENTRIES-1:0] add_hv, col_hv;
  logic [SLOT_W-1:0]  free_idx;
  logic               has_free;
  logic [WORDS*WORD_W-1:0] col_data;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      add_hv[e] = vld[e] && (tag[e] == add_line);
      col_hv[e] = vld[e] && (tag[e] == col_line);
    end
  end

  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!vld[e]) begin
        free_idx = SLOT_W'(e);
        has_free = 1'b1;
      end
    end
  end

  always_comb begin
    col_data = '0;
    for (int e = 0; e < ENTRIES; e++)
      for (int k = 0; k < WORDS; k++)
        if (col_hv[e]) col_data[k*WORD_W +: WORD_W] = col_data[k*WORD_W +: WORD_W] | dat[e][k];
  end

  wire add_hit = |add_hv;
  assign add_ready = !col_valid && (add_hit || has_free);
  wire fire = add_valid && add_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld         <= '0;
      start_valid <= 1'b0;
      start_line  <= '0;
      rep_valid   <= 1'b0;
      rep_hit     <= 1'b0;
      rep_data    <= '0;
    end else begin
      start_valid <= fire && !add_hit;
      start_line  <= add_line;
      rep_valid   <= col_valid;
      rep_hit     <= col_valid && (|col_hv);
      rep_data    <= col_valid ? col_data : '0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (col_valid && col_hv[e]) vld[e] <= 1'b0;
        if (fire && add_hv[e]) begin
          dat[e][add_word] <= dat[e][add_word] + add_value;
        end else if (fire && !add_hit && free_idx == SLOT_W'(e)) begin
          vld[e] <= 1'b1;
          tag[e] <= add_line;
          for (int k = 0; k < WORDS; k++)
            dat[e][k] <= (IDX_W'(k) == add_word) ? add_value : '0;
        end
      end
    end
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(add_hv)); // R9
  AST_HIT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (add_valid && add_ready && add_hit) |=> !start_valid); // R3
  AST_COLLECT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |=> rep_valid); // R5
  AST_MISS_REPLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_hit) |-> (rep_data == '0)); // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((&vld) && add_valid && !add_hit) |-> !add_ready); // R7
  AST_COLLECT_BLOCKS_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> !add_ready); // R8
endmodule

// File: tb/red_line_buf_test.sv
module red_line_buf_test;
  localparam int LINE_W = 26;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic add_valid = 0, col_valid = 0;
  logic add_ready, start_valid, rep_valid, rep_hit;
  logic [LINE_W-1:0] add_line = '0, col_line = '0, start_line;
  logic [3:0] add_word = '0;
  logic [31:0] add_value = '0;
  logic [511:0] rep_data;

  red_line_buf uut (
    .clk(clk), .rst_n(rst_n), .add_valid(add_valid), .add_ready(add_ready),
    .add_line(add_line), .add_word(add_word), .add_value(add_value),
    .start_valid(start_valid), .start_line(start_line),
    .col_valid(col_valid), .col_line(col_line),
    .rep_valid(rep_valid), .rep_hit(rep_hit), .rep_data(rep_data));

  int total = 0, bad = 0;
  logic        mval [16];
  logic [31:0] mdat [16][16];

  // kind(1: 0 add,1 collect) line(4) word(4) value(32) exp(1: start for add, hit for collect)
  localparam int NV = 11;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 4'd1, 4'd0,  32'd5,        1'b1},
    {1'b0, 4'd1, 4'd0,  32'd7,        1'b0},
    {1'b0, 4'd1, 4'd15, 32'd9,        1'b0},
    {1'b0, 4'd2, 4'd3,  32'd100,      1'b1},
    {1'b0, 4'd2, 4'd3,  32'hFFFFFFFF, 1'b0},
    {1'b1, 4'd1, 4'd0,  32'd0,        1'b1},
    {1'b1, 4'd1, 4'd0,  32'd0,        1'b0},
    {1'b0, 4'd1, 4'd2,  32'd3,        1'b1},
    {1'b1, 4'd2, 4'd0,  32'd0,        1'b1},
    {1'b1, 4'd1, 4'd0,  32'd0,        1'b1},
    {1'b1, 4'd5, 4'd0,  32'd0,        1'b0}
  };

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_add(input logic [3:0] l, input logic [3:0] w, input logic [31:0] v,
                        input logic exp_st, input string req);
    @(negedge clk);
    add_valid = 1; add_line = LINE_W'(l); add_word = w; add_value = v;
    #1 chk({req, " ready"}, 512'(add_ready), 512'(1));
    @(posedge clk); #1;
    add_valid = 0;
    chk({req, " start"}, 512'(start_valid), 512'(exp_st));
    if (exp_st) chk({req, " start_line"}, 512'(start_line), 512'(l));
    if (!mval[l]) begin
      mval[l] = 1;
      for (int k = 0; k < 16; k++) mdat[l][k] = 0;
    end
    mdat[l][w] = mdat[l][w] + v;
  endtask

  task automatic do_col(input logic [3:0] l, input logic exp_hit, input string req);
    logic [511:0] e;
    e = '0;
    if (mval[l]) for (int k = 0; k < 16; k++) e[k*32 +: 32] = mdat[l][k];
    @(negedge clk);
    col_valid = 1; col_line = LINE_W'(l);
    @(posedge clk); #1;
    col_valid = 0;
    chk({req, " rep_valid"}, 512'(rep_valid), 512'(1));
    chk({req, " rep_hit"}, 512'(rep_hit), 512'(exp_hit));
    chk({req, " rep_data"}, rep_data, e);
    mval[l] = 0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mval[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 add_ready", 512'(add_ready), 512'(1));
    chk("R1 start_valid", 512'(start_valid), 512'(0));
    chk("R1 rep_valid", 512'(rep_valid), 512'(0));

    // table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][41]) do_col(VEC[i][40:37], VEC[i][0], "R5_R6 table collect");
      else do_add(VEC[i][40:37], VEC[i][36:33], VEC[i][32:1], VEC[i][0], "R2_R3_R4 table add");
    end

    // R7: fill four entries, then a fifth line is refused
    do_add(4'd8, 4'd1, 32'd11, 1'b1, "R7 fill");
    do_add(4'd9, 4'd2, 32'd12, 1'b1, "R7 fill");
    do_add(4'd10, 4'd3, 32'd13, 1'b1, "R7 fill");
    do_add(4'd11, 4'd4, 32'd14, 1'b1, "R7 fill");
    @(negedge clk);
    add_valid = 1; add_line = LINE_W'(12); add_word = 0; add_value = 32'd99;
    #1 chk("R7 full stall", 512'(add_ready), 512'(0));
    @(posedge clk); #1 add_valid = 0;
    chk("R7 no start when full", 512'(start_valid), 512'(0));
    do_add(4'd9, 4'd2, 32'd1, 1'b0, "R7 hit while full");
    do_col(4'd12, 1'b0, "R7 refused add left nothing");
    do_col(4'd8, 1'b1, "R7 free one");
    do_add(4'd12, 4'd0, 32'd99, 1'b1, "R7 accepted after free");

    // R8: collect blocks a simultaneous add
    @(negedge clk);
    add_valid = 1; add_line = LINE_W'(9); add_word = 2; add_value = 32'd500;
    col_valid = 1; col_line = LINE_W'(10);
    #1 chk("R8 add blocked by collect", 512'(add_ready), 512'(0));
    @(posedge clk); #1;
    add_valid = 0; col_valid = 0;
    mval[10] = 0;
    do_col(4'd9, 1'b1, "R8 blocked add had no effect");

    // R5: line restarts from zero after collect
    do_add(4'd12, 4'd5, 32'd4, 1'b0, "R5 pre");
    do_col(4'd12, 1'b1, "R5 collect");
    do_add(4'd12, 4'd5, 32'd6, 1'b1, "R5 restart start");
    do_col(4'd12, 1'b1, "R5 restart from zero");
    do_col(4'd11, 1'b1, "R9 untouched line");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule